// File: doc/BRIEF.md
# Configurable SPI Master Frame Engine

This block is a synchronous serial master that runs one full-duplex frame each time it accepts a start request. A 16-bit control word selects the frame length, the frame format, the idle level of the serial clock, which clock edge captures input data, and a per-bit clock count. A separate 8-bit divisor sets an even prescale ahead of that count. The parallel transmit word is shifted out on `mosi` while `miso` is shifted into the receive word. The engine asserts the active-low select for the whole frame and pulses `done` once when the received word is ready.

The control word is captured when a frame is accepted, so software-side logic can prepare the next setting while a frame is in flight. Settings that name a frame length below four bits, or any format other than plain SPI, are refused and produce no bus activity.

Top module: `spi_frame_master`

## Requirements
- R1: The frame carries N = ctrlWord[3:0] + 1 bits (4 to 16), most significant bit first; only txWord[N-1:0] is sent, and rxWord bits above N-1 read as zero.
- R2: A start request while ctrlWord[3:0] is 0, 1 or 2 is refused: busy stays 0, ssN stays 1 and sck does not toggle.
- R3: A start request while ctrlWord[5:4] is not 0 is refused in the same way.
- R4: Between frames sck rests at ctrlWord[6] (0 gives low, 1 gives high), and each frame begins and ends at that level.
- R5: With ctrlWord[7] at 0, miso is captured on odd-numbered sck edges (1st, 3rd, ...) and mosi changes on even ones, with the first bit on mosi from the moment ssN falls; with ctrlWord[7] at 1, miso is captured on even edges and mosi changes on odd edges after the first.
- R6: Each half bit lasts H = max(prescale[7:1], 1) * (ctrlWord[15:8] + 1) clock cycles, so odd divisors lose their low bit and a divisor of 0 acts as 2.
- R7: ssN falls one clock after an accepted start, the first sck edge follows 2H cycles later, the frame has exactly 2N sck edges, and ssN rises (2N+2)H cycles after it fell, in the same cycle as a single-cycle done pulse that presents the new rxWord.
- R8: Changes to ctrlWord, prescale or txWord during a frame do not affect that frame.
- R9: During reset and after it, busy, done, mosi and rxWord are 0, ssN is 1 and sck is 0.
- R10: A start request while busy is ignored and does not lengthen or restart the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWord | input | 16 | Size [3:0], format [5:4], idle level [6], capture edge [7], per-bit count [15:8] |
| prescale | input | 8 | Even prescale divisor |
| txWord | input | 16 | Word to transmit |
| start | input | 1 | Request one frame |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rxWord | output | 16 | Last received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssN | output | 1 | Active-low slave select |

## Verification
The hardest case to reach from the ports is a change of the control word, divisor and transmit word in the middle of a frame together with a second start request, since the frame must keep its original length, timing and data. The bench starts an 8-bit frame, then rewrites every input to a 16-bit setting and pulses start again while busy, and checks the edge count, select duration and both data words against the original setting. A slave model in the bench follows the capture-edge choice, so a wrong edge in either phase setting shows up as corrupted data in one direction.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int CTRL_W  = 16;
  localparam int WORD_W  = 16;
  localparam int PRE_W   = 8;
  localparam int LEN_W   = 4;
  localparam int SCR_LSB = 8;
  localparam int SCR_W   = CTRL_W - SCR_LSB;
  localparam int HALF_W  = PRE_W + SCR_W;
  localparam int TICK_W  = LEN_W + 2;
  localparam int MIN_LEN_CODE = 3;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [PRE_W-1:0]  prescale,
  output dpStrobe_t         strobe,
  output logic [LEN_W-1:0]  lenM1,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              ssN
);
  logic [HALF_W-1:0] halfQ, halfNext, timer;
  logic [TICK_W-1:0] tickNum, nextTick, lastTick, edgeNum;
  logic [PRE_W-1:0]  preHalf;
  logic              cphaQ, sckQ, okToStart, tick, isEdge, oddEdge;

  assign preHalf   = prescale >> 1;
  assign halfNext  = HALF_W'((preHalf == '0) ? 1 : preHalf)
                   * (HALF_W'(ctrlWord[CTRL_W-1:SCR_LSB]) + HALF_W'(1));
  assign okToStart = start && !busy
                   && (ctrlWord[LEN_W-1:0] >= LEN_W'(MIN_LEN_CODE))
                   && (ctrlWord[5:4] == 2'b00);

  assign tick     = busy && (timer == halfQ - HALF_W'(1));
  assign nextTick = tickNum + TICK_W'(1);
  assign lastTick = TICK_W'({lenM1, 1'b0}) + TICK_W'(4);
  assign edgeNum  = nextTick - TICK_W'(1);
  assign oddEdge  = edgeNum[0];
  assign isEdge   = tick && (nextTick >= TICK_W'(2)) && (nextTick < lastTick);

  always_comb begin
    strobe.load     = okToStart;
    strobe.finish   = tick && (nextTick == lastTick);
    strobe.sampleIn = isEdge && (cphaQ ? !oddEdge : oddEdge);
    strobe.shiftOut = isEdge && (cphaQ ? (oddEdge && edgeNum != TICK_W'(1)) : !oddEdge);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ssN     <= 1'b1;
      sckQ    <= 1'b0;
      cphaQ   <= 1'b0;
      lenM1   <= '0;
      halfQ   <= HALF_W'(1);
      timer   <= '0;
      tickNum <= '0;
    end else begin
      done <= 1'b0;
      if (okToStart) begin
        busy    <= 1'b1;
        ssN     <= 1'b0;
        timer   <= '0;
        tickNum <= '0;
        halfQ   <= halfNext;
        lenM1   <= ctrlWord[LEN_W-1:0];
        cphaQ   <= ctrlWord[7];
        sckQ    <= ctrlWord[6];
      end else if (busy) begin
        if (tick) begin
          timer   <= '0;
          tickNum <= nextTick;
          if (strobe.finish) begin
            busy <= 1'b0;
            ssN  <= 1'b1;
            done <= 1'b1;
          end else if (isEdge) begin
            sckQ <= ~sckQ;
          end
        end else begin
          timer <= timer + HALF_W'(1);
        end
      end
    end
  end

  assign sck = busy ? sckQ : ctrlWord[6];
endmodule

// File: rtl/spi_frame_datapath.sv
module spi_frame_datapath
  import spi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [LEN_W-1:0]  lenM1,
  input  logic              busy,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end else begin
        if (strobe.shiftOut) txShift <= txShift << 1;
        if (strobe.sampleIn) rxShift <= {rxShift[WORD_W-2:0], miso};
      end
      if (strobe.finish) rxWord <= rxShift;
    end
  end

  assign mosi = busy && txShift[lenM1];
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [WORD_W-1:0] txWord,
  input  logic              start,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rxWord,
  output logic              sck,
  output logic              mosi,
  output logic              ssN
);
  dpStrobe_t        strobe;
  logic [LEN_W-1:0] lenM1;

  spi_frame_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ctrlWord(ctrlWord),
    .prescale(prescale), .strobe(strobe), .lenM1(lenM1),
    .busy(busy), .done(done), .sck(sck), .ssN(ssN)
  );

  spi_frame_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lenM1(lenM1), .busy(busy),
    .txWord(txWord), .miso(miso), .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_frame_checker.sv
module spi_frame_checker
  import spi_frame_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sck,
  input logic              ssN
);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_select_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> done);

  assert_bad_size_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && ctrlWord[3:0] < 4'd3) |=> (!busy && ssN));

  assert_bad_format_refused_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && ctrlWord[5:4] != 2'b00) |=> (!busy && ssN));

  assert_frame_idle_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> (sck == $past(ctrlWord[6])));

  assert_idle_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $stable(ctrlWord)) |-> $stable(sck));
endmodule

bind spi_frame_master spi_frame_checker uChecker (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .start(start),
  .busy(busy), .done(done), .sck(sck), .ssN(ssN)
);

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ctrlWord = '0;
  logic [7:0]  prescale = '0;
  logic [15:0] txWord = '0;
  logic        start = 1'b0;
  logic        miso = 1'b0;
  logic        busy, done, sck, mosi, ssN;
  logic [15:0] rxWord;

  int testsRun = 0;
  int testsFailed = 0;

  spi_frame_master dut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .prescale(prescale),
    .txWord(txWord), .start(start), .miso(miso), .busy(busy), .done(done),
    .rxWord(rxWord), .sck(sck), .mosi(mosi), .ssN(ssN)
  );

  always #5 clk = ~clk;

  // ctrl[55:40] prescale[39:32] tx[31:16] slaveTx[15:0]
  localparam logic [55:0] VEC [6] = '{
    {16'h0107, 8'd2, 16'hFFA5, 16'h123C},
    {16'h004F, 8'd4, 16'hBEEF, 16'h5A3C},
    {16'h0283, 8'd3, 16'h00F9, 16'hFFF6},
    {16'h00CB, 8'd0, 16'hF3C5, 16'hE9A6},
    {16'h0309, 8'd6, 16'h0E2D, 16'hFC71},
    {16'h008E, 8'd1, 16'hC0DE, 16'hB7E3}
  };

  // slave model and frame monitor
  int cyc = 0, fallCyc = 0, riseCyc = 0, firstEdgeCyc = 0, edges = 0, doneCnt = 0;
  int bitPos = 0;
  logic prevSsN = 1'b1, prevSck = 1'b0;
  logic slvCpha = 1'b0;
  int slvLen = 8;
  logic [15:0] slvTx = '0, got = '0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prevSsN && !ssN) begin
      fallCyc = cyc; edges = 0; firstEdgeCyc = 0; doneCnt = 0; got = '0;
      bitPos = slvLen - 1;
      miso = slvTx[bitPos];
    end else if (!ssN && sck != prevSck) begin
      edges = edges + 1;
      if (edges == 1) firstEdgeCyc = cyc;
      if (slvCpha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
        got = {got[14:0], mosi};
      end else if (!(slvCpha && edges == 1) && bitPos > 0) begin
        bitPos = bitPos - 1;
        miso = slvTx[bitPos];
      end
    end
    if (!prevSsN && ssN) riseCyc = cyc;
    if (done) doneCnt = doneCnt + 1;
    prevSsN = ssN;
    prevSck = sck;
  end

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone();
    bit seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    if (!seen) begin
      testsRun++; testsFailed++;
      $display("FAIL R7: actual no done expected done");
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic int halfOf(input logic [15:0] c, input logic [7:0] p);
    int ph = int'(p >> 1);
    if (ph == 0) ph = 1;
    return ph * (int'(c[15:8]) + 1);
  endfunction

  task automatic checkFrame(input logic [15:0] c, input logic [7:0] p,
                            input logic [15:0] tx, input logic [15:0] stx);
    int n = int'(c[3:0]) + 1;
    int h = halfOf(c, p);
    logic [15:0] mask = 16'((32'd1 << n) - 1);
    check("R1 rxWord", int'(rxWord), int'(stx & mask));
    check("R5 slave got", int'(got), int'(tx & mask));
    check("R7 edge count", edges, 2 * n);
    check("R6 lead time", firstEdgeCyc - fallCyc, 2 * h);
    check("R7 select low time", riseCyc - fallCyc, (2 * n + 2) * h);
    check("R7 done pulses", doneCnt, 1);
    check("R4 idle sck", int'(sck), int'(c[6]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 busy", int'(busy), 0);
    check("R9 ssN", int'(ssN), 1);
    check("R9 sck", int'(sck), 0);
    check("R9 done", int'(done), 0);
    check("R9 mosi", int'(mosi), 0);
    check("R9 rxWord", int'(rxWord), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 busy after release", int'(busy), 0);

    // vector table walk
    for (int i = 0; i < 6; i++) begin
      ctrlWord = VEC[i][55:40];
      prescale = VEC[i][39:32];
      txWord   = VEC[i][31:16];
      slvTx    = VEC[i][15:0];
      slvCpha  = VEC[i][47];
      slvLen   = int'(VEC[i][43:40]) + 1;
      @(negedge clk);
      pulseStart();
      waitDone();
      checkFrame(VEC[i][55:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0]);
    end

    // R2 unsupported size codes
    for (int code = 0; code < 3; code++) begin
      ctrlWord = 16'h0000 | 16'(code);
      prescale = 8'd2;
      edges = 0;
      pulseStart();
      repeat (20) @(negedge clk);
      check("R2 busy refused", int'(busy), 0);
      check("R2 ssN high", int'(ssN), 1);
    end

    // R3 non-SPI formats
    for (int f = 1; f < 4; f++) begin
      ctrlWord = 16'h0007 | 16'(f << 4);
      pulseStart();
      repeat (20) @(negedge clk);
      check("R3 busy refused", int'(busy), 0);
      check("R3 ssN high", int'(ssN), 1);
    end

    // R8 / R10 mid-frame changes and repeated start
    ctrlWord = 16'h0107; prescale = 8'd2; txWord = 16'h00C3;
    slvTx = 16'h0096; slvCpha = 1'b0; slvLen = 8;
    @(negedge clk);
    pulseStart();
    repeat (5) @(negedge clk);
    ctrlWord = 16'h00CF; prescale = 8'd8; txWord = 16'hFFFF;
    pulseStart();
    waitDone();
    check("R8 rxWord", int'(rxWord), 16'h0096);
    check("R8 slave got", int'(got), 16'h00C3);
    check("R8 edge count", edges, 16);
    check("R10 select low time", riseCyc - fallCyc, 18 * 2);
    check("R10 done pulses", doneCnt, 1);
    check("R4 idle follows new level", int'(sck), 1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule